// File: doc/BRIEF.md
# Host FIFO Front End with Aliased Data Ports and Peekable Status

This block sits between a 32-bit host register bus and a network MAC. It holds four FIFOs: a transmit data FIFO that the host fills and the MAC drains, and three FIFOs that the MAC fills and the host drains: receive data, receive status and transmit status. The host reaches each FIFO through decoded word addresses. Each data FIFO answers at eight consecutive word addresses, so a host can burst through a linear address range and still hit the same queue. Each status FIFO has two views. One removes the oldest entry when read. The other returns the oldest entry and leaves it in place.

Every FIFO runs a small occupancy state machine with three states: FS_EMPTY, FS_PART and FS_FULL. Each cycle the next state is derived from the next level. A push-only cycle moves FS_EMPTY to FS_PART, and moves FS_PART to FS_FULL when the last slot fills. A pop-only cycle moves FS_FULL to FS_PART, and moves FS_PART to FS_EMPTY when the last entry leaves. A cycle with both a push and a pop keeps the state as it is. An accepted push or pop with a depth of one goes directly between FS_EMPTY and FS_FULL. A push is refused in FS_FULL and a pop is refused in FS_EMPTY.

Host reads return data through a register, one clock after the access. Level registers report the occupancy of each FIFO. A flag register holds two sticky error bits, and the host clears them by writing ones.

Top module: `fifo_host_front`

## Requirements
- R1: After reset all four FIFOs are empty and all levels are zero. mac_txd_empty is 1, the three MAC full outputs are 0, hst_rdata is 0 and both flag bits are 0.
- R2: A host write to any word address from 00h to 1Ch, with the low two address bits at zero, pushes hst_wdata into the TX data FIFO. The MAC sees the oldest word on mac_txd_data whenever mac_txd_empty is 0, and mac_txd_pop removes it.
- R3: The MAC pushes receive words with mac_rxd_push. A host read of any word address from 20h to 3Ch pops the oldest word, which appears on hst_rdata on the clock after the read.
- R4: A host read at 40h pops the oldest RX status entry. A host read at 48h pops the oldest TX status entry.
- R5: A host read at 44h returns the oldest RX status entry, and a read at 4Ch returns the oldest TX status entry. Neither read removes the entry. Peeking an empty status FIFO returns 0 and sets no flag.
- R6: A popping host read of an empty FIFO (20h–3Ch, 40h, 48h) returns 0 and leaves the FIFO unchanged. It also sets underflow flag bit 0 of the flag register at 60h, and the bit stays set until it is cleared.
- R7: A host write to the TX data FIFO while it is full is discarded, and it sets overflow flag bit 1 at 60h. A MAC push into a full FIFO is discarded and sets no flag.
- R8: Host reads return zero-extended levels: 50h gives the RX data level, 54h the TX data level, 58h the RX status level and 5Ch the TX status level.
- R9: When a push and a pop reach the same non-empty FIFO in the same cycle, the level is unchanged and the first-in first-out order is kept.
- R10: A host write to 60h clears each flag bit whose matching hst_wdata bit (bit 0 or bit 1) is 1, and leaves the other bit as it was.
- R11: mac_rxd_full, mac_txs_full and mac_rxs_full are 1 exactly when their FIFO holds its parameter depth. mac_txd_empty is 1 exactly when the TX data FIFO holds nothing.
- R12: Each FIFO depth is a separate parameter, and no level ever goes above its depth.
- R13: Any other address, including one with a non-zero low two bits, reads as 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_cs | input | 1 | Host access strobe, one access per cycle |
| hst_we | input | 1 | 1 for a write, 0 for a read |
| hst_addr | input | 8 | Host byte address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Registered host read data |
| mac_txd_pop | input | 1 | MAC removes the head of the TX data FIFO |
| mac_txd_data | output | 32 | Head of the TX data FIFO |
| mac_txd_empty | output | 1 | TX data FIFO empty |
| mac_rxd_push | input | 1 | MAC pushes into the RX data FIFO |
| mac_rxd_data | input | 32 | RX data word |
| mac_rxd_full | output | 1 | RX data FIFO full |
| mac_txs_push | input | 1 | MAC pushes into the TX status FIFO |
| mac_txs_data | input | 32 | TX status word |
| mac_txs_full | output | 1 | TX status FIFO full |
| mac_rxs_push | input | 1 | MAC pushes into the RX status FIFO |
| mac_rxs_data | input | 32 | RX status word |
| mac_rxs_full | output | 1 | RX status FIFO full |

## Verification
The hardest case to reach is a FIFO at its full or empty boundary in the same cycle that the other side acts on it. Examples are a host write into a full TX data FIFO while the MAC pops, and a host status pop on the cycle the MAC pushes into an empty FIFO. The random stimulus runs in phases with different push and pop probabilities. These phases drive each FIFO repeatedly to both ends and hold it there while the host keeps issuing mixed accesses. Directed sequences before the random phases cover alias sweeps, peek-then-pop, empty reads and overflow.

// File: rtl/fhf_pkg.sv
package fhf_pkg;
    localparam int HW = 32;

    typedef enum logic [1:0] {
        FS_EMPTY = 2'd0,
        FS_PART  = 2'd1,
        FS_FULL  = 2'd2
    } fifo_state_e;

    typedef struct packed {
        logic txd_wr;
        logic rxd_rd;
        logic rxs_pop;
        logic rxs_peek;
        logic txs_pop;
        logic txs_peek;
        logic lvl_rxd;
        logic lvl_txd;
        logic lvl_rxs;
        logic lvl_txs;
        logic flag_rd;
        logic flag_wr;
    } hdec_t;

    localparam logic [7:0] A_RXS_POP  = 8'h40;
    localparam logic [7:0] A_RXS_PEEK = 8'h44;
    localparam logic [7:0] A_TXS_POP  = 8'h48;
    localparam logic [7:0] A_TXS_PEEK = 8'h4C;
    localparam logic [7:0] A_LVL_RXD  = 8'h50;
    localparam logic [7:0] A_LVL_TXD  = 8'h54;
    localparam logic [7:0] A_LVL_RXS  = 8'h58;
    localparam logic [7:0] A_LVL_TXS  = 8'h5C;
    localparam logic [7:0] A_FLAGS    = 8'h60;
endpackage

// File: rtl/fhf_fifo.sv
module fhf_fifo
    import fhf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [LW-1:0] level,
    output logic          empty,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [LW-1:0] level_q, level_n;
    fifo_state_e   state_q, state_n;
    logic          push_ok, pop_ok;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // refuse push in FS_FULL and pop in FS_EMPTY
    always_comb begin
        push_ok = 1'b0;
        pop_ok  = 1'b0;
        unique case (state_q)
            FS_EMPTY: push_ok = push;
            FS_PART: begin
                push_ok = push;
                pop_ok  = pop;
            end
            FS_FULL:  pop_ok  = pop;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            level_q <= '0;
        end else begin
            if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
            level_q <= level_n;
        end
    end

    // next state from next level
    always_comb begin
        level_n = level_q + LW'(push_ok) - LW'(pop_ok);
        if (level_n == '0)
            state_n = FS_EMPTY;
        else if (level_n == LW'(DEPTH))
            state_n = FS_FULL;
        else
            state_n = FS_PART;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FS_EMPTY;
        else        state_q <= state_n;
    end

    always_comb begin
        empty = 1'b0;
        full  = 1'b0;
        unique case (state_q)
            FS_EMPTY: empty = 1'b1;
            FS_PART:  ;
            FS_FULL:  full  = 1'b1;
            default:  ;
        endcase
    end

    assign head  = mem[rd_ptr];
    assign level = level_q;

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= LW'(DEPTH)); // R12
    AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (level_q == '0) && (rd_ptr == $past(rd_ptr))); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> full && (wr_ptr == $past(wr_ptr))); // R7
    AST_BOTH_KEEP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !empty && !full) |=> $stable(level_q)); // R9
    AST_STATE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (empty == (level_q == '0)) && (full == (level_q == LW'(DEPTH)))); // R11
endmodule

// File: rtl/fhf_decode.sv
module fhf_decode
    import fhf_pkg::*;
(
    input  logic       cs,
    input  logic       we,
    input  logic [7:0] addr,
    output hdec_t      dec
);
    logic rd, wr;

    always_comb begin
        rd  = cs && !we;
        wr  = cs && we;
        dec = '0;
        dec.txd_wr   = wr && (addr[7:5] == 3'b000) && (addr[1:0] == 2'b00);
        dec.rxd_rd   = rd && (addr[7:5] == 3'b001) && (addr[1:0] == 2'b00);
        dec.rxs_pop  = rd && (addr == A_RXS_POP);
        dec.rxs_peek = rd && (addr == A_RXS_PEEK);
        dec.txs_pop  = rd && (addr == A_TXS_POP);
        dec.txs_peek = rd && (addr == A_TXS_PEEK);
        dec.lvl_rxd  = rd && (addr == A_LVL_RXD);
        dec.lvl_txd  = rd && (addr == A_LVL_TXD);
        dec.lvl_rxs  = rd && (addr == A_LVL_RXS);
        dec.lvl_txs  = rd && (addr == A_LVL_TXS);
        dec.flag_rd  = rd && (addr == A_FLAGS);
        dec.flag_wr  = wr && (addr == A_FLAGS);
    end
endmodule

// File: rtl/fhf_sticky.sv
module fhf_sticky (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_unf,
    input  logic       set_ovf,
    input  logic       clr_en,
    input  logic [1:0] clr_bits,
    output logic [1:0] flags
);
    logic [1:0] flags_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q[0] <= set_unf | (flags_q[0] & ~(clr_en & clr_bits[0]));
            flags_q[1] <= set_ovf | (flags_q[1] & ~(clr_en & clr_bits[1]));
        end
    end

    assign flags = flags_q;

    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[0] && !(clr_en && clr_bits[0])) |=> flags_q[0]); // R6
    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_ovf |=> flags_q[1]); // R7
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && clr_bits[1] && !set_ovf) |=> !flags_q[1]); // R10
endmodule

// File: rtl/fifo_host_front.sv
module fifo_host_front
    import fhf_pkg::*;
#(
    parameter int TXD_DEPTH = 16,
    parameter int RXD_DEPTH = 16,
    parameter int TXS_DEPTH = 8,
    parameter int RXS_DEPTH = 8,
    localparam int TXD_LW   = $clog2(TXD_DEPTH + 1),
    localparam int RXD_LW   = $clog2(RXD_DEPTH + 1),
    localparam int TXS_LW   = $clog2(TXS_DEPTH + 1),
    localparam int RXS_LW   = $clog2(RXS_DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hst_cs,
    input  logic        hst_we,
    input  logic [7:0]  hst_addr,
    input  logic [31:0] hst_wdata,
    output logic [31:0] hst_rdata,
    input  logic        mac_txd_pop,
    output logic [31:0] mac_txd_data,
    output logic        mac_txd_empty,
    input  logic        mac_rxd_push,
    input  logic [31:0] mac_rxd_data,
    output logic        mac_rxd_full,
    input  logic        mac_txs_push,
    input  logic [31:0] mac_txs_data,
    output logic        mac_txs_full,
    input  logic        mac_rxs_push,
    input  logic [31:0] mac_rxs_data,
    output logic        mac_rxs_full
);
    hdec_t              dec;
    logic [HW-1:0]      rxd_head, txs_head, rxs_head;
    logic [TXD_LW-1:0]  txd_level;
    logic [RXD_LW-1:0]  rxd_level;
    logic [TXS_LW-1:0]  txs_level;
    logic [RXS_LW-1:0]  rxs_level;
    logic               txd_full, rxd_empty, txs_empty, rxs_empty;
    logic               set_unf, set_ovf, rd_any;
    logic [1:0]         flags;
    logic [HW-1:0]      rd_val, rdata_q;

    fhf_decode u_dec (.cs(hst_cs), .we(hst_we), .addr(hst_addr), .dec(dec));

    fhf_fifo #(.DEPTH(TXD_DEPTH), .W(HW)) u_txd (
        .clk(clk), .rst_n(rst_n), .push(dec.txd_wr), .push_data(hst_wdata),
        .pop(mac_txd_pop), .head(mac_txd_data), .level(txd_level),
        .empty(mac_txd_empty), .full(txd_full));

    fhf_fifo #(.DEPTH(RXD_DEPTH), .W(HW)) u_rxd (
        .clk(clk), .rst_n(rst_n), .push(mac_rxd_push), .push_data(mac_rxd_data),
        .pop(dec.rxd_rd), .head(rxd_head), .level(rxd_level),
        .empty(rxd_empty), .full(mac_rxd_full));

    fhf_fifo #(.DEPTH(TXS_DEPTH), .W(HW)) u_txs (
        .clk(clk), .rst_n(rst_n), .push(mac_txs_push), .push_data(mac_txs_data),
        .pop(dec.txs_pop), .head(txs_head), .level(txs_level),
        .empty(txs_empty), .full(mac_txs_full));

    fhf_fifo #(.DEPTH(RXS_DEPTH), .W(HW)) u_rxs (
        .clk(clk), .rst_n(rst_n), .push(mac_rxs_push), .push_data(mac_rxs_data),
        .pop(dec.rxs_pop), .head(rxs_head), .level(rxs_level),
        .empty(rxs_empty), .full(mac_rxs_full));

    assign set_unf = (dec.rxd_rd  && rxd_empty) ||
                     (dec.rxs_pop && rxs_empty) ||
                     (dec.txs_pop && txs_empty);
    assign set_ovf = dec.txd_wr && txd_full;

    fhf_sticky u_flags (
        .clk(clk), .rst_n(rst_n), .set_unf(set_unf), .set_ovf(set_ovf),
        .clr_en(dec.flag_wr), .clr_bits(hst_wdata[1:0]), .flags(flags));

    assign rd_any = hst_cs && !hst_we;

    // read mux; an empty FIFO reads as zero
    always_comb begin
        rd_val = '0;
        if (dec.rxd_rd)
            rd_val = rxd_empty ? '0 : rxd_head;
        else if (dec.rxs_pop || dec.rxs_peek)
            rd_val = rxs_empty ? '0 : rxs_head;
        else if (dec.txs_pop || dec.txs_peek)
            rd_val = txs_empty ? '0 : txs_head;
        else if (dec.lvl_rxd)
            rd_val = HW'(rxd_level);
        else if (dec.lvl_txd)
            rd_val = HW'(txd_level);
        else if (dec.lvl_rxs)
            rd_val = HW'(rxs_level);
        else if (dec.lvl_txs)
            rd_val = HW'(txs_level);
        else if (dec.flag_rd)
            rd_val = HW'(flags);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_any) rdata_q <= rd_val;
    end

    assign hst_rdata = rdata_q;

    AST_DEC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dec)); // R13
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.rxd_rd && rxd_empty) |=> (hst_rdata == '0)); // R6
    AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.rxs_peek && !mac_rxs_push) |=> $stable(rxs_level)); // R5
    AST_TX_PUSH_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.txd_wr && !txd_full && !mac_txd_pop) |=> (txd_level == $past(txd_level) + 1'b1)); // R2
endmodule

// File: tb/tb_fifo_host_front.sv
`timescale 1ns/1ps
module tb_fifo_host_front;
    localparam int TXD_D = 16;
    localparam int RXD_D = 16;
    localparam int TXS_D = 8;
    localparam int RXS_D = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        hst_cs, hst_we;
    logic [7:0]  hst_addr;
    logic [31:0] hst_wdata, hst_rdata;
    logic        mac_txd_pop, mac_txd_empty;
    logic [31:0] mac_txd_data;
    logic        mac_rxd_push, mac_rxd_full;
    logic [31:0] mac_rxd_data;
    logic        mac_txs_push, mac_txs_full;
    logic [31:0] mac_txs_data;
    logic        mac_rxs_push, mac_rxs_full;
    logic [31:0] mac_rxs_data;

    always #2 clk = ~clk;

    fifo_host_front #(.TXD_DEPTH(TXD_D), .RXD_DEPTH(RXD_D),
                      .TXS_DEPTH(TXS_D), .RXS_DEPTH(RXS_D)) dut (.*);

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] q_txd[$], q_rxd[$], q_txs[$], q_rxs[$];
    bit          m_unf, m_ovf;
    bit          exp_valid;
    logic [31:0] exp_rd;
    string       exp_tag;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] head_or_zero(ref logic [31:0] q[$]);
        return (q.size() > 0) ? q[0] : 32'h0;
    endfunction

    // model: compute expected read data and update queues for one clock edge
    task automatic model_apply();
        bit rd, wr;
        bit unf_set, ovf_set;
        int n_txd, n_rxd, n_txs, n_rxs;
        logic [7:0] a;
        a       = hst_addr;
        rd      = hst_cs && !hst_we;
        wr      = hst_cs && hst_we;
        n_txd   = q_txd.size();
        n_rxd   = q_rxd.size();
        n_txs   = q_txs.size();
        n_rxs   = q_rxs.size();
        unf_set = 1'b0;
        ovf_set = 1'b0;
        exp_valid = rd;
        exp_rd  = 32'h0;
        exp_tag = "R13 unmapped read";
        if (rd) begin
            if (a >= 8'h20 && a <= 8'h3C && a[1:0] == 2'b00) begin
                exp_tag = "R3 rx data alias read";
                if (n_rxd > 0) exp_rd = q_rxd[0];
                else begin unf_set = 1'b1; exp_tag = "R6 empty rx data read"; end
            end else if (a == 8'h40) begin
                exp_tag = "R4 rx status pop";
                if (n_rxs > 0) exp_rd = q_rxs[0]; else unf_set = 1'b1;
            end else if (a == 8'h48) begin
                exp_tag = "R4 tx status pop";
                if (n_txs > 0) exp_rd = q_txs[0]; else unf_set = 1'b1;
            end else if (a == 8'h44) begin
                exp_tag = "R5 rx status peek"; exp_rd = head_or_zero(q_rxs);
            end else if (a == 8'h4C) begin
                exp_tag = "R5 tx status peek"; exp_rd = head_or_zero(q_txs);
            end else if (a == 8'h50) begin exp_tag = "R8 rxd level"; exp_rd = n_rxd;
            end else if (a == 8'h54) begin exp_tag = "R8 txd level"; exp_rd = n_txd;
            end else if (a == 8'h58) begin exp_tag = "R8 rxs level"; exp_rd = n_rxs;
            end else if (a == 8'h5C) begin exp_tag = "R8 txs level"; exp_rd = n_txs;
            end else if (a == 8'h60) begin
                exp_tag = "R10 flag read"; exp_rd = {30'h0, m_ovf, m_unf};
            end
        end
        // tx data: host pushes, MAC pops
        if (mac_txd_pop && n_txd > 0) void'(q_txd.pop_front());
        if (wr && a <= 8'h1C && a[1:0] == 2'b00) begin
            if (n_txd < TXD_D) q_txd.push_back(hst_wdata); else ovf_set = 1'b1;
        end
        // rx data
        if (rd && a >= 8'h20 && a <= 8'h3C && a[1:0] == 2'b00 && n_rxd > 0) void'(q_rxd.pop_front());
        if (mac_rxd_push && n_rxd < RXD_D) q_rxd.push_back(mac_rxd_data);
        // status
        if (rd && a == 8'h40 && n_rxs > 0) void'(q_rxs.pop_front());
        if (mac_rxs_push && n_rxs < RXS_D) q_rxs.push_back(mac_rxs_data);
        if (rd && a == 8'h48 && n_txs > 0) void'(q_txs.pop_front());
        if (mac_txs_push && n_txs < TXS_D) q_txs.push_back(mac_txs_data);
        // flags
        if (wr && a == 8'h60) begin
            if (hst_wdata[0]) m_unf = 1'b0;
            if (hst_wdata[1]) m_ovf = 1'b0;
        end
        if (unf_set) m_unf = 1'b1;
        if (ovf_set) m_ovf = 1'b1;
    endtask

    task automatic step();
        model_apply();
        @(posedge clk);
        @(negedge clk);
        if (exp_valid) chk(hst_rdata == exp_rd, exp_tag, hst_rdata, exp_rd);
        chk(mac_txd_empty == (q_txd.size() == 0), "R11 txd empty", 32'(mac_txd_empty), 32'(q_txd.size() == 0));
        if (q_txd.size() > 0) chk(mac_txd_data == q_txd[0], "R2 txd head", mac_txd_data, q_txd[0]);
        chk(mac_rxd_full == (q_rxd.size() == RXD_D), "R11 rxd full", 32'(mac_rxd_full), 32'(q_rxd.size() == RXD_D));
        chk(mac_txs_full == (q_txs.size() == TXS_D), "R11 txs full", 32'(mac_txs_full), 32'(q_txs.size() == TXS_D));
        chk(mac_rxs_full == (q_rxs.size() == RXS_D), "R11 rxs full", 32'(mac_rxs_full), 32'(q_rxs.size() == RXS_D));
        hst_cs = 0; hst_we = 0; hst_addr = 0; hst_wdata = 0;
        mac_txd_pop = 0; mac_rxd_push = 0; mac_txs_push = 0; mac_rxs_push = 0;
    endtask

    task automatic hw(input logic [7:0] a, input logic [31:0] d);
        hst_cs = 1; hst_we = 1; hst_addr = a; hst_wdata = d; step();
    endtask

    task automatic hr(input logic [7:0] a);
        hst_cs = 1; hst_we = 0; hst_addr = a; step();
    endtask

    initial begin
        #(4ns * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 0; hst_cs = 0; hst_we = 0; hst_addr = 0; hst_wdata = 0;
        mac_txd_pop = 0; mac_rxd_push = 0; mac_txs_push = 0; mac_rxs_push = 0;
        mac_rxd_data = 0; mac_txs_data = 0; mac_rxs_data = 0;
        m_unf = 0; m_ovf = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(hst_rdata == 0, "R1 rdata", hst_rdata, 0);
        chk(mac_txd_empty == 1, "R1 txd empty", 32'(mac_txd_empty), 1);
        chk({mac_rxd_full, mac_txs_full, mac_rxs_full} == 3'b000, "R1 fulls", 32'({mac_rxd_full, mac_txs_full, mac_rxs_full}), 0);
        hr(8'h50); hr(8'h54); hr(8'h58); hr(8'h5C); hr(8'h60);

        // R2 alias sweep then MAC drain
        for (int i = 0; i < 8; i++) hw(8'(i * 4), 32'hA000_0000 + 32'(i));
        hr(8'h54);
        for (int i = 0; i < 8; i++) begin mac_txd_pop = 1; step(); end
        // R3 rx data through every alias
        for (int i = 0; i < 8; i++) begin mac_rxd_push = 1; mac_rxd_data = 32'hB000_0000 + 32'(i); step(); end
        for (int i = 0; i < 8; i++) hr(8'h20 + 8'(i * 4));
        // R4 / R5 status peek then pop
        for (int i = 0; i < 3; i++) begin
            mac_rxs_push = 1; mac_rxs_data = 32'hC000_0000 + 32'(i);
            mac_txs_push = 1; mac_txs_data = 32'hD000_0000 + 32'(i); step();
        end
        hr(8'h44); hr(8'h44); hr(8'h4C); hr(8'h58);
        for (int i = 0; i < 3; i++) begin hr(8'h40); hr(8'h48); end
        hr(8'h44); hr(8'h4C); hr(8'h60);  // R5 empty peek: 0, no flag
        // R6 empty pops
        hr(8'h24); hr(8'h60); hr(8'h40); hr(8'h48); hr(8'h50);
        // R10 clear bit 0 only
        hw(8'h60, 32'h1); hr(8'h60);
        // R7 overflow
        for (int i = 0; i < TXD_D + 2; i++) hw(8'h1C, 32'hE000_0000 + 32'(i));
        hr(8'h54); hr(8'h60);
        for (int i = 0; i < RXD_D + 1; i++) begin mac_rxd_push = 1; mac_rxd_data = 32'(i); step(); end
        hr(8'h50); hr(8'h60);
        // R13 misaligned and unmapped
        hw(8'h02, 32'hFFFF_FFFF); hr(8'h54); hr(8'h21); hr(8'h50); hr(8'h7C);
        // R9 push and pop on the same cycle, full TX FIFO partially drained
        for (int i = 0; i < 4; i++) begin mac_txd_pop = 1; step(); end
        for (int i = 0; i < 6; i++) begin hst_cs = 1; hst_we = 1; hst_addr = 8'h08; hst_wdata = 32'hF000_0000 + 32'(i); mac_txd_pop = 1; step(); end
        hr(8'h54);
        // R10 clear both
        hw(8'h60, 32'h3); hr(8'h60);

        // random phases with varying bias
        for (int ph = 0; ph < 12; ph++) begin
            int pp, pq;
            pp = (ph % 3 == 0) ? 80 : (ph % 3 == 1) ? 20 : 50;
            pq = 100 - pp;
            for (int c = 0; c < 600; c++) begin
                int r;
                r = $urandom % 14;
                mac_rxd_push = ($urandom % 100) < pp; mac_rxd_data = $urandom;
                mac_txs_push = ($urandom % 100) < pp; mac_txs_data = $urandom;
                mac_rxs_push = ($urandom % 100) < pp; mac_rxs_data = $urandom;
                mac_txd_pop  = ($urandom % 100) < pq;
                hst_cs = 1; hst_wdata = $urandom;
                case (r)
                    0, 1, 2: begin hst_we = 1; hst_addr = 8'(($urandom % 8) * 4); if (pp > 50) hst_cs = 1; end
                    3, 4:    begin hst_we = 0; hst_addr = 8'h20 + 8'(($urandom % 8) * 4); end
                    5: begin hst_we = 0; hst_addr = 8'h40; end
                    6: begin hst_we = 0; hst_addr = 8'h44; end
                    7: begin hst_we = 0; hst_addr = 8'h48; end
                    8: begin hst_we = 0; hst_addr = 8'h4C; end
                    9: begin hst_we = 0; hst_addr = 8'h50 + 8'(($urandom % 4) * 4); end
                    10: begin hst_we = 0; hst_addr = 8'h60; end
                    11: begin hst_we = 1; hst_addr = 8'h60; end
                    default: hst_cs = 0;
                endcase
                step();
            end
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule